// File: doc/BRIEF.md
# Receive Checksum Verification Engine

This block sits inline on a byte-wide receive frame stream with start-of-frame, end-of-frame, valid and ready signals. While the frame passes through unchanged, it reads the Ethernet type field and the IPv4 or IPv6 header that follows. Along the way it accumulates the IPv4 header checksum and the TCP, UDP or ICMP checksum. The TCP, UDP and ICMPv6 sums include the pseudo-header. No frame is ever dropped or flagged on the side.

When checking is enabled, the block appends a four-byte status trailer after the last byte of every frame. The trailer holds two 16-bit verdicts. The first is for the IP header and the second is for the transport payload. A verdict of 0x0000 means the checksum is correct. A verdict of 0xFFFF means the field was not checked. Any other value is the residue of a wrong checksum.

Software turns checking on and off with an enable request. The read-back of that request changes only between frames. The per-protocol check mask can only be written while the read-back shows checking is off.

Top module: `rxcsum_engine`

## Requirements
- R1: While checking is active for a frame, every byte of that frame is forwarded unchanged. Exactly four trailer bytes follow the last frame byte, and out_eof is asserted only on the fourth trailer byte.
- R2: The first trailer field is the IP header verdict and the second is the transport verdict. Each field is sent low byte first.
- R3: Each verdict is the ones'-complement of the folded ones'-complement sum over the covered bytes, with the stored checksum included. It is 0x0000 for a correct checksum, and for a wrong one it is a value that is neither 0x0000 nor 0xFFFF.
- R4: For an IPv6 frame (type 0x86DD) the IP header verdict is 0xFFFF. For a frame whose type is neither 0x0800 nor 0x86DD, both verdicts are 0xFFFF.
- R5: The transport verdict covers protocol 6 (TCP) and protocol 17 (UDP) over both IP versions, protocol 1 (ICMP) over IPv4 and protocol 58 (ICMPv6) over IPv6. TCP, UDP and ICMPv6 include the pseudo-header: source and destination addresses, protocol number and transport length. ICMP over IPv4 does not. Any other protocol gives 0xFFFF.
- R6: If a frame ends before its IP header is complete, both verdicts are 0xFFFF. If it ends before the transport length that the IP header declares, the transport verdict is 0xFFFF. Bytes after the declared IP length are not summed.
- R7: For an IPv4 fragment, the transport verdict is 0xFFFF. A fragment is a packet with the more-fragments flag set or a nonzero fragment offset.
- R8: The check mask enables each check: bit 0 the IPv4 header, bit 1 TCP, bit 2 UDP, bit 3 ICMP and ICMPv6. A check whose bit is 0 reports 0xFFFF. After reset all mask bits are 1.
- R9: A mask write takes effect only while en_status reads 0. Otherwise it is ignored.
- R10: en_status follows en_req only at a frame boundary. Once a frame has started with checking active, en_status stays 1 until that frame's trailer has been sent.
- R11: When checking is inactive, frames pass through unchanged with no trailer, and out_eof is asserted on the last frame byte.
- R12: After reset, en_status is 0 and out_valid is 0.
- R13: During the trailer, in_ready is 0. While out_ready is 0, the trailer byte on out_data is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Receive frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block accepts the input byte |
| out_data | output | 8 | Forwarded byte or trailer byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| en_req | input | 1 | Software request to enable checking |
| en_status | output | 1 | Read-back of the active enable |
| mask_we | input | 1 | Write strobe for the check mask |
| mask_wdata | input | 4 | New check mask value |

## Verification
The hardest case to reach is dropping the enable request while a frame is still in flight. The read-back must then stay high through that frame's trailer and fall only afterwards. The bench clears en_req partway through a frame while output back-pressure stretches the transfer. It samples en_status in the same cycle the last trailer byte is handed over, and again two cycles later. Verdicts are checked against frames the bench builds itself, with checksums computed in the bench. Single-byte corruptions, truncations, padding, fragments and mask changes are then applied to those frames to force each verdict class.

// File: rtl/rxcsum_pkg.sv
package rxcsum_pkg;
  localparam int SUM_W   = 32;
  localparam int CHK_N   = 4;
  localparam int ETH_LEN = 14;
  localparam int V6_L4   = 54;
  localparam logic [15:0] ET_V4 = 16'h0800;
  localparam logic [15:0] ET_V6 = 16'h86DD;
  localparam logic [7:0]  PR_ICMP = 8'd1;
  localparam logic [7:0]  PR_TCP  = 8'd6;
  localparam logic [7:0]  PR_UDP  = 8'd17;
  localparam logic [7:0]  PR_ICMP6 = 8'd58;
  localparam int M_IP = 0, M_TCP = 1, M_UDP = 2, M_ICMP = 3;

  typedef enum logic {ST_PASS, ST_TRL} ostate_e;

  // add one byte as the high or low half of a 16-bit word
  function automatic logic [SUM_W-1:0] acc_byte(input logic [SUM_W-1:0] acc,
                                                input logic [7:0] b, input logic hi);
    return acc + (hi ? SUM_W'({b, 8'h00}) : SUM_W'(b));
  endfunction

  // end-around carry fold to 16 bits
  function automatic logic [15:0] fold16(input logic [SUM_W-1:0] s);
    logic [16:0] t1;
    logic [16:0] t2;
    t1 = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    t2 = {1'b0, t1[15:0]} + 17'(t1[16]);
    return t2[15:0];
  endfunction

  function automatic logic [15:0] verdict(input logic [SUM_W-1:0] s);
    return ~fold16(s);
  endfunction
endpackage

// File: rtl/rxcsum_parse.sv
module rxcsum_parse
  import rxcsum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sof,
  input  logic [7:0]       data,
  output logic [CNT_W-1:0] nbytes,
  output logic [15:0]      etype,
  output logic [3:0]       ver,
  output logic [3:0]       ihl,
  output logic [15:0]      iplen,
  output logic [7:0]       proto,
  output logic             frag,
  output logic [SUM_W-1:0] hsum,
  output logic [SUM_W-1:0] asum,
  output logic [SUM_W-1:0] lsum
);
  localparam int EW = CNT_W + 2;
  localparam logic [EW-1:0] P_ETH  = EW'(ETH_LEN);
  localparam logic [EW-1:0] P_V6L4 = EW'(V6_L4);

  logic [CNT_W-1:0] pos;
  logic [EW-1:0]    p, hdr_end, l4_lo, l4_hi;
  logic             is4, is6, hi, in_hdr, in_addr, in_l4;

  assign pos     = sof ? '0 : nbytes;
  assign p       = EW'(pos);
  assign hi      = ~pos[0];
  assign is4     = (etype == ET_V4);
  assign is6     = (etype == ET_V6);
  assign hdr_end = P_ETH + EW'({ihl, 2'b00});
  assign l4_lo   = is6 ? P_V6L4 : hdr_end;
  assign l4_hi   = (is6 ? P_V6L4 : P_ETH) + EW'(iplen);
  assign in_hdr  = is4 && (p == P_ETH || (p > P_ETH && p < hdr_end));
  assign in_addr = (is4 && p >= EW'(26) && p < EW'(34)) ||
                   (is6 && p >= EW'(22) && p < EW'(54));
  assign in_l4   = (is4 || is6) && p >= l4_lo && p < l4_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbytes <= '0; etype <= '0; ver <= '0; ihl <= '0; iplen <= '0;
      proto <= '0; frag <= 1'b0; hsum <= '0; asum <= '0; lsum <= '0;
    end else if (take) begin
      nbytes <= (pos == '1) ? pos : pos + 1'b1;
      hsum   <= sof ? '0 : (in_hdr  ? acc_byte(hsum, data, hi) : hsum);
      asum   <= sof ? '0 : (in_addr ? acc_byte(asum, data, hi) : asum);
      lsum   <= sof ? '0 : (in_l4   ? acc_byte(lsum, data, hi) : lsum);
      if (sof) begin
        etype <= '0; ver <= '0; ihl <= '0; iplen <= '0; proto <= '0; frag <= 1'b0;
      end else begin
        if (p == EW'(12)) etype[15:8] <= data;
        if (p == EW'(13)) etype[7:0]  <= data;
        if (p == P_ETH)   {ver, ihl}  <= data;
        if (is4) begin
          if (p == EW'(16)) iplen[15:8] <= data;
          if (p == EW'(17)) iplen[7:0]  <= data;
          if (p == EW'(20)) frag        <= data[5] | (|data[4:0]);
          if (p == EW'(21)) frag        <= frag | (|data);
          if (p == EW'(23)) proto       <= data;
        end
        if (is6) begin
          if (p == EW'(18)) iplen[15:8] <= data;
          if (p == EW'(19)) iplen[7:0]  <= data;
          if (p == EW'(20)) proto       <= data;
        end
      end
    end
  end
endmodule

// File: rtl/rxcsum_result.sv
module rxcsum_result
  import rxcsum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] nbytes,
  input  logic [15:0]      etype,
  input  logic [3:0]       ver,
  input  logic [3:0]       ihl,
  input  logic [15:0]      iplen,
  input  logic [7:0]       proto,
  input  logic             frag,
  input  logic [SUM_W-1:0] hsum,
  input  logic [SUM_W-1:0] asum,
  input  logic [SUM_W-1:0] lsum,
  input  logic [CHK_N-1:0] mask,
  output logic [15:0]      ip_res,
  output logic [15:0]      l4_res
);
  localparam int EW = CNT_W + 2;

  logic             v4, v6, hdr_ok, len_ok, tcp, udp, icmp, mbit, pseudo, l4_go;
  logic [5:0]       hlen;
  logic [EW-1:0]    nb, hdr_end, l4_end;
  logic [15:0]      l4len;
  logic [SUM_W-1:0] l4sum;

  assign hlen    = {ihl, 2'b00};
  assign v4      = (etype == ET_V4) && (ver == 4'd4) && (ihl >= 4'd5);
  assign v6      = (etype == ET_V6) && (ver == 4'd6);
  assign nb      = EW'(nbytes);
  assign hdr_end = EW'(ETH_LEN) + EW'(hlen);
  assign hdr_ok  = v4 ? (nb >= hdr_end) : (v6 && nb >= EW'(V6_L4));
  assign l4_end  = (v6 ? EW'(V6_L4) : EW'(ETH_LEN)) + EW'(iplen);
  assign len_ok  = (v6 || iplen >= 16'(hlen)) && nb >= l4_end;
  assign l4len   = v6 ? iplen : iplen - 16'(hlen);

  assign tcp    = (proto == PR_TCP);
  assign udp    = (proto == PR_UDP);
  assign icmp   = v6 ? (proto == PR_ICMP6) : (proto == PR_ICMP);
  assign mbit   = (tcp && mask[M_TCP]) || (udp && mask[M_UDP]) || (icmp && mask[M_ICMP]);
  assign pseudo = tcp || udp || (v6 && icmp);
  assign l4sum  = lsum + (pseudo ? asum + SUM_W'(proto) + SUM_W'(l4len) : '0);
  assign l4_go  = hdr_ok && len_ok && !(v4 && frag) && mbit;

  assign ip_res = (v4 && hdr_ok && mask[M_IP]) ? verdict(hsum) : 16'hFFFF;
  assign l4_res = l4_go ? verdict(l4sum) : 16'hFFFF;
endmodule

// File: rtl/rxcsum_ctrl.sv
module rxcsum_ctrl
  import rxcsum_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             en_req,
  input  logic             mask_we,
  input  logic [CHK_N-1:0] mask_wdata,
  output logic             en_q,
  output logic [CHK_N-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (boundary) en_q <= en_req;
      if (mask_we && !en_q) mask_q <= mask_wdata;
    end
  end
endmodule

// File: rtl/rxcsum_engine.sv
module rxcsum_engine
  import rxcsum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_valid,
  input  logic             out_ready,
  input  logic             en_req,
  output logic             en_status,
  input  logic             mask_we,
  input  logic [CHK_N-1:0] mask_wdata
);
  ostate_e          state;
  logic [1:0]       trl_idx;
  logic             trl_active, trl_last, take, in_frame, boundary, en_q;
  logic [CHK_N-1:0] mask_q;
  logic [CNT_W-1:0] nbytes;
  logic [15:0]      etype, iplen, ip_res, l4_res;
  logic [3:0]       ver, ihl;
  logic [7:0]       proto, trl_byte;
  logic             frag;
  logic [SUM_W-1:0] hsum, asum, lsum;

  assign trl_active = (state == ST_TRL);
  assign trl_last   = (trl_idx == 2'd3);
  assign in_ready   = !trl_active && out_ready;
  assign take       = in_valid && in_ready;
  assign boundary   = (!trl_active && !in_frame && !take) ||
                      (!trl_active && take && in_eof && !en_q) ||
                      (trl_active && trl_last && out_ready);

  always_comb begin
    case (trl_idx)
      2'd0:    trl_byte = ip_res[7:0];
      2'd1:    trl_byte = ip_res[15:8];
      2'd2:    trl_byte = l4_res[7:0];
      default: trl_byte = l4_res[15:8];
    endcase
  end

  assign out_valid = trl_active || in_valid;
  assign out_data  = trl_active ? trl_byte : in_data;
  assign out_sof   = !trl_active && in_sof;
  assign out_eof   = trl_active ? trl_last : (in_eof && !en_q);
  assign en_status = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_PASS;
      trl_idx  <= 2'd0;
      in_frame <= 1'b0;
    end else begin
      if (take) in_frame <= !in_eof;
      if (!trl_active) begin
        if (take && in_eof && en_q) begin
          state   <= ST_TRL;
          trl_idx <= 2'd0;
        end
      end else if (out_ready) begin
        trl_idx <= trl_idx + 2'd1;
        if (trl_last) state <= ST_PASS;
      end
    end
  end

  rxcsum_parse #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst_n(rst_n), .take(take), .sof(in_sof), .data(in_data),
    .nbytes(nbytes), .etype(etype), .ver(ver), .ihl(ihl), .iplen(iplen),
    .proto(proto), .frag(frag), .hsum(hsum), .asum(asum), .lsum(lsum)
  );

  rxcsum_result #(.CNT_W(CNT_W)) u_result (
    .nbytes(nbytes), .etype(etype), .ver(ver), .ihl(ihl), .iplen(iplen),
    .proto(proto), .frag(frag), .hsum(hsum), .asum(asum), .lsum(lsum),
    .mask(mask_q), .ip_res(ip_res), .l4_res(l4_res)
  );

  rxcsum_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .en_req(en_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .en_q(en_q), .mask_q(mask_q)
  );
endmodule

// File: rtl/rxcsum_engine_chk.sv
module rxcsum_engine_chk
  import rxcsum_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             en_status,
  input logic             trl_active,
  input logic             trl_last,
  input logic             in_frame,
  input logic [CHK_N-1:0] mask_q
);
  AST_TRL_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    trl_active |-> !in_ready);  // R13
  AST_TRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trl_active && !out_ready) |=> (trl_active && out_valid && $stable(out_data)));  // R13
  AST_TRL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (trl_active && trl_last && out_ready) |=> !trl_active);  // R1
  AST_EN_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && en_status) |=> en_status);  // R10
  AST_EN_HELD_IN_TRL: assert property (@(posedge clk) disable iff (!rst_n)
    (trl_active && !trl_last) |=> $stable(en_status));  // R10
  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_status |=> $stable(mask_q));  // R9
endmodule

bind rxcsum_engine rxcsum_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .en_status(en_status),
  .trl_active(trl_active), .trl_last(trl_last), .in_frame(in_frame), .mask_q(mask_q)
);

// File: tb/rxcsum_engine_bench.sv
module rxcsum_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_sof = 1'b0, in_eof = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic       in_ready, out_sof, out_eof, out_valid, en_status;
  logic [7:0] out_data;
  logic       en_req = 1'b0, mask_we = 1'b0;
  logic [3:0] mask_wdata = '0;

  always #5 clk = ~clk;

  rxcsum_engine u_rxcsum_engine (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_valid(out_valid), .out_ready(out_ready), .en_req(en_req),
    .en_status(en_status), .mask_we(mask_we), .mask_wdata(mask_wdata)
  );

  // verdict classes: 0 -> 0x0000, 1 -> 0xFFFF, 2 -> checksum error residue
  typedef struct packed {
    logic [1:0] kind;   // 0 IPv4, 1 IPv6, 2 other type
    logic [7:0] proto;
    logic [7:0] plen;
    logic [1:0] bad;    // 1 corrupt IPv4 header, 2 corrupt payload
    logic       frag;
    logic [3:0] pad;
    logic [5:0] trunc;
    logic [1:0] eip;
    logic [1:0] el4;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{0, 6, 40, 0, 0, 0, 0, 0, 0},
    '{0, 17, 23, 0, 0, 0, 0, 0, 0},
    '{0, 1, 24, 0, 0, 0, 0, 0, 0},
    '{1, 6, 32, 0, 0, 0, 0, 1, 0},
    '{1, 17, 21, 0, 0, 0, 0, 1, 0},
    '{1, 58, 20, 0, 0, 0, 0, 1, 0},
    '{2, 0, 0, 0, 0, 0, 0, 1, 1},
    '{0, 6, 28, 1, 0, 0, 0, 2, 0},
    '{0, 17, 30, 2, 0, 0, 0, 0, 2},
    '{0, 6, 24, 0, 1, 0, 0, 0, 1},
    '{0, 6, 20, 0, 0, 0, 30, 1, 1},
    '{0, 17, 26, 0, 0, 0, 3, 0, 1},
    '{0, 17, 20, 0, 0, 6, 0, 0, 0},
    '{0, 47, 22, 0, 0, 0, 0, 0, 1},
    '{1, 6, 26, 2, 0, 0, 0, 1, 2}
  };
  localparam string TAGS [0:NV-1] = '{"R5", "R5", "R5", "R4", "R4", "R4", "R4", "R3",
                                      "R3", "R7", "R6", "R6", "R6", "R5", "R4"};

  logic [7:0] fr [0:511];
  logic [7:0] ob [0:519];
  int flen, olen, nchk = 0, nfail = 0, cyc = 0;
  bit done_all = 0;

  function automatic logic [31:0] sum16(input int s, input int n);
    logic [31:0] a = '0;
    for (int i = 0; i < n; i++)
      a += (i % 2 == 0) ? {16'h0, fr[s+i], 8'h0} : {24'h0, fr[s+i]};
    return a;
  endfunction

  function automatic logic [15:0] fin(input logic [31:0] a);
    logic [31:0] t = a;
    while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return ~t[15:0];
  endfunction

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_cls(input string tag, input logic [15:0] v, input logic [1:0] cls);
    bit ok;
    ok = (cls == 0) ? (v == 16'h0000) : (cls == 1) ? (v == 16'hFFFF)
                    : (v != 16'h0000 && v != 16'hFFFF);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %s", tag, v,
               cls == 0 ? "0000" : cls == 1 ? "ffff" : "error residue");
    end
  endtask

  task automatic build(input vec_t v);
    int l4s, ck;
    logic [31:0] ps;
    logic [15:0] c;
    for (int i = 0; i < 12; i++) fr[i] = 8'(8'h10 + i * 3);
    l4s = 34;
    if (v.kind == 2) begin
      fr[12] = 8'h08; fr[13] = 8'h06;
      for (int i = 14; i < 42; i++) fr[i] = 8'(i * 5);
      flen = 42;
      return;
    end
    if (v.kind == 0) begin
      fr[12] = 8'h08; fr[13] = 8'h00;
      fr[14] = 8'h45; fr[15] = 8'h00;
      fr[16] = 8'((20 + v.plen) >> 8); fr[17] = 8'(20 + v.plen);
      fr[18] = 8'h12; fr[19] = 8'h34;
      fr[20] = v.frag ? 8'h20 : 8'h00; fr[21] = 8'h00;
      fr[22] = 8'h40; fr[23] = v.proto; fr[24] = 8'h00; fr[25] = 8'h00;
      fr[26] = 8'h0a; fr[27] = 8'h00; fr[28] = 8'h00; fr[29] = 8'h01;
      fr[30] = 8'hc0; fr[31] = 8'ha8; fr[32] = 8'h01; fr[33] = 8'h02;
      c = fin(sum16(14, 20));
      fr[24] = c[15:8]; fr[25] = c[7:0];
      ps = (v.proto == 8'd1) ? 32'h0 : sum16(26, 8) + 32'(v.proto) + 32'(v.plen);
    end else begin
      fr[12] = 8'h86; fr[13] = 8'hDD;
      fr[14] = 8'h60; fr[15] = 8'h00; fr[16] = 8'h00; fr[17] = 8'h00;
      fr[18] = 8'h00; fr[19] = v.plen; fr[20] = v.proto; fr[21] = 8'h40;
      for (int i = 0; i < 16; i++) begin
        fr[22+i] = 8'(8'h20 + i);
        fr[38+i] = 8'(8'h80 + i * 3);
      end
      l4s = 54;
      ps = sum16(22, 32) + 32'(v.proto) + 32'(v.plen);
    end
    for (int i = 0; i < v.plen; i++) fr[l4s+i] = 8'(i * 13 + 5);
    ck = (v.proto == 8'd6) ? 16 : (v.proto == 8'd17) ? 6 : 2;
    fr[l4s+ck] = 8'h00; fr[l4s+ck+1] = 8'h00;
    c = fin(sum16(l4s, v.plen) + ps);
    fr[l4s+ck] = c[15:8]; fr[l4s+ck+1] = c[7:0];
    if (v.bad == 1) fr[22] = fr[22] ^ 8'h01;
    if (v.bad == 2) fr[l4s+v.plen-1] = fr[l4s+v.plen-1] ^ 8'h5A;
    for (int i = 0; i < v.pad; i++) fr[l4s+v.plen+i] = 8'hEE;
    flen = l4s + v.plen + v.pad - v.trunc;
  endtask

  // sends fr[0:flen-1], collects the output frame into ob; drops en_req at byte drop_at
  task automatic send(input int drop_at, output bit st_end);
    int k = 0;
    bit fin_f = 0;
    olen = 0;
    st_end = 0;
    while (!fin_f) begin
      @(negedge clk);
      cyc++;
      if (k == drop_at) en_req = 1'b0;
      out_ready = (cyc % 3) != 2;
      if (k < flen) begin
        in_valid = 1'b1; in_data = fr[k]; in_sof = (k == 0); in_eof = (k == flen - 1);
      end else begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        ob[olen] = out_data;
        olen++;
        if (out_eof) begin
          fin_f = 1;
          st_end = en_status;
        end
      end
      if (in_valid && in_ready) k++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; out_ready = 1'b1;
  endtask

  function automatic int data_mismatch();
    int m = 0;
    for (int i = 0; i < flen; i++) if (ob[i] !== fr[i]) m++;
    return m;
  endfunction

  task automatic check_trailer(input string tag, input logic [1:0] eip, input logic [1:0] el4);
    chk({tag, " R1 trailer length"}, olen == flen + 4, olen, flen + 4);
    chk({tag, " R1 R13 data passthrough"}, data_mismatch() == 0, data_mismatch(), 0);
    chk_cls({tag, " R2 ip field"}, {ob[flen+1], ob[flen]}, eip);
    chk_cls({tag, " R2 l4 field"}, {ob[flen+3], ob[flen+2]}, el4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit st;
    vec_t tv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 out_valid after reset", out_valid == 1'b0, out_valid, 0);
    chk("R12 en_status after reset", en_status == 1'b0, en_status, 0);

    @(negedge clk); en_req = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R10 enable read-back", en_status == 1'b1, en_status, 1);

    for (int n = 0; n < NV; n++) begin
      build(VECS[n]);
      send(-1, st);
      check_trailer(TAGS[n], VECS[n].eip, VECS[n].el4);
    end

    // mask write while enabled must be ignored
    @(negedge clk); mask_we = 1'b1; mask_wdata = 4'b0000;
    @(negedge clk); mask_we = 1'b0;
    tv = '{0, 6, 30, 0, 0, 0, 0, 0, 0};
    build(tv);
    send(-1, st);
    check_trailer("R9 locked mask", 2'd0, 2'd0);

    // enable dropped mid-frame: trailer still sent, read-back falls after it
    build(tv);
    send(10, st);
    chk("R10 status at last trailer byte", st == 1'b1, st, 1);
    chk("R10 trailer kept after drop", olen == flen + 4, olen, flen + 4);
    repeat (2) @(negedge clk);
    #1 chk("R10 status after frame", en_status == 1'b0, en_status, 0);

    // disabled: no trailer
    build(tv);
    send(-1, st);
    chk("R11 passthrough length", olen == flen, olen, flen);
    chk("R11 passthrough data", data_mismatch() == 0, data_mismatch(), 0);

    // mask: IP header off, TCP on, UDP off, ICMP on
    @(negedge clk); mask_we = 1'b1; mask_wdata = 4'b1010;
    @(negedge clk); mask_we = 1'b0; en_req = 1'b1;
    repeat (2) @(negedge clk);
    tv = '{0, 17, 24, 0, 0, 0, 0, 0, 0};
    build(tv);
    send(-1, st);
    check_trailer("R8 udp masked", 2'd1, 2'd1);
    tv = '{0, 6, 24, 0, 0, 0, 0, 0, 0};
    build(tv);
    send(-1, st);
    check_trailer("R8 tcp kept", 2'd1, 2'd0);

    done_all = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule